// File: doc/BRIEF.md
# Machine-Mode Interrupt Entry Unit

This unit samples the core's level-sensitive interrupt request lines into a 32-bit pending vector. It picks the one request to take and, when the core signals that it is taking a trap, computes the new machine-mode cause value and status fields. The request lines are software, timer, external, fifteen fast lines and one non-maskable line. Each line is registered once. The selection logic then masks the registered bits with the per-source enable vector and the global interrupt-enable bit. The non-maskable line needs neither.

Among the eligible requests, the one with the highest bit index wins. The chosen index is offered to the core together with a valid flag. On a take strobe with a valid request, the unit does four things. It writes the cause value. It copies the current global enable into the previous-enable field. It clears the global enable field. It forces the privilege field to machine mode. A non-maskable trap also arms a guard. While the guard is armed, the still-high non-maskable line cannot trap again. A pulse on the handler-done input releases the guard.

Top module: `irq_entry_unit`

## Requirements
- R1: One clock after the lines are sampled, the readable pending vector holds software at bit 3, timer at bit 7, external at bit 11 and fast line k at bit 16+k, with every other bit zero.
- R2: Bit 31 of the readable pending vector is always 0, even while the non-maskable line is high.
- R3: When several eligible requests are pending, the valid output is 1 and the ID output is the highest eligible bit index. The ID is a 5-bit binary index. It is 0 when nothing is valid.
- R4: A maskable request whose bit in the 31-bit enable input is 0 is not taken. The enable bit position equals the request's pending bit position.
- R5: Maskable requests are eligible only while the global-enable input is 1.
- R6: The non-maskable request (ID 31) is eligible whatever the enable input and the global-enable input are.
- R7: A take strobe while valid is 1 sets the cause output on the next clock to bit 31 = 1 and bits 30:0 = the ID selected in the strobe cycle.
- R8: On the same edge, the previous-enable output takes the global-enable input, the global-enable status output goes to 0, and the 2-bit privilege output becomes 2'b11.
- R9: A take strobe while valid is 0 changes neither the cause nor any status output.
- R10: After a non-maskable trap, the non-maskable request is not eligible until the handler-done input has been 1 at a clock edge. Other eligible requests are still selected during that time.
- R11: Reset, which is synchronous and active low, clears the pending vector, the cause, the global-enable and previous-enable status outputs and the non-maskable guard. It sets the privilege output to 2'b11.
- R12: Requests are levels. A bit stays pending while its line is high and clears one clock after the line drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| sw_req_i | input | 1 | Software interrupt line |
| tmr_req_i | input | 1 | Timer interrupt line |
| ext_req_i | input | 1 | External interrupt line |
| fast_req_i | input | 15 | Fast interrupt lines |
| nmi_req_i | input | 1 | Non-maskable interrupt line |
| enable_i | input | 31 | Per-source enable vector |
| gie_i | input | 1 | Current global interrupt-enable bit |
| take_i | input | 1 | Core takes a trap this cycle |
| nmi_done_i | input | 1 | Non-maskable handler finished |
| pending_o | output | 32 | Readable pending vector |
| irq_valid_o | output | 1 | An eligible request exists |
| irq_id_o | output | 5 | Index of the selected request |
| cause_o | output | 32 | Cause value written on trap entry |
| stat_mie_o | output | 1 | Status global-enable field |
| stat_mpie_o | output | 1 | Status previous-enable field |
| stat_priv_o | output | 2 | Status privilege field |

## Verification
Two functions can meet in one cycle: a take strobe, and a newly raised higher-index line that is being registered at the same edge. The bench raises the take strobe and a higher fast line together while an external request is already selected. It then checks two things. The cause must carry the old external index. After the edge, the ID must already point at the fast line. A second pairing holds the non-maskable line high through its handler-done pulse. The request must reappear exactly one edge after the pulse and never before it.

// File: rtl/irq_entry_pkg.sv
// Shared constants of the interrupt entry unit: bit positions of each
// request source in the pending vector and the machine privilege code.
// Assumes a 32-bit machine word and fast lines starting at bit 16.
package irq_entry_pkg;
    localparam int unsigned XLEN      = 32;
    localparam int unsigned NUM_FAST  = 15;
    localparam int unsigned SW_IDX    = 3;
    localparam int unsigned TMR_IDX   = 7;
    localparam int unsigned EXT_IDX   = 11;
    localparam int unsigned FAST_BASE = 16;
    localparam int unsigned IDW       = $clog2(XLEN);
    localparam logic [1:0]  PRIV_MACH = 2'b11;
endpackage

// File: rtl/irq_pend_reg.sv
// Packs the request lines into one vector and registers it once.
// Assumes FAST_BASE + NUM_FAST == XLEN - 1; the top bit holds the
// non-maskable line. Unassigned bits are held at zero.
module irq_pend_reg #(
    parameter int unsigned XLEN      = irq_entry_pkg::XLEN,
    parameter int unsigned NUM_FAST  = irq_entry_pkg::NUM_FAST,
    parameter int unsigned FAST_BASE = irq_entry_pkg::FAST_BASE
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                sw_req_i,
    input  logic                tmr_req_i,
    input  logic                ext_req_i,
    input  logic [NUM_FAST-1:0] fast_req_i,
    input  logic                nmi_req_i,
    output logic [XLEN-1:0]     pend_o
);
    localparam int unsigned NMI_IDX = XLEN - 1;

    logic [XLEN-1:0] raw;
    logic [XLEN-1:0] pend_q;

    // Place each line at its fixed bit position.
    always_comb begin
        raw                         = '0;
        raw[irq_entry_pkg::SW_IDX]  = sw_req_i;
        raw[irq_entry_pkg::TMR_IDX] = tmr_req_i;
        raw[irq_entry_pkg::EXT_IDX] = ext_req_i;
        for (int k = 0; k < int'(NUM_FAST); k++) begin
            raw[FAST_BASE + k] = fast_req_i[k];
        end
        raw[NMI_IDX]                = nmi_req_i;
    end

    // Sample the levels once per clock.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) pend_q <= '0;
        else         pend_q <= raw;
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/irq_select.sv
// Masks the registered requests and picks the highest eligible index.
// Assumes the top bit is the non-maskable request, which bypasses both
// the enable vector and the global enable but can be blocked by a guard.
module irq_select #(
    parameter int unsigned XLEN = irq_entry_pkg::XLEN,
    parameter int unsigned IDW  = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] pend_i,
    input  logic [XLEN-2:0] enable_i,
    input  logic            gie_i,
    input  logic            nmi_block_i,
    output logic            valid_o,
    output logic [IDW-1:0]  id_o
);
    localparam int unsigned NMI_IDX = XLEN - 1;

    logic [XLEN-1:0] elig;

    // Build the eligible set from pending, enables and the guard.
    always_comb begin
        elig[XLEN-2:0] = pend_i[XLEN-2:0] & enable_i & {(XLEN-1){gie_i}};
        elig[NMI_IDX]  = pend_i[NMI_IDX] & ~nmi_block_i;
    end

    // Scan upward so that the highest set index is the last written.
    always_comb begin
        id_o = '0;
        for (int i = 0; i < int'(XLEN); i++) begin
            if (elig[i]) id_o = IDW'(i);
        end
    end

    assign valid_o = |elig;
endmodule

// File: rtl/irq_trap_csr.sv
// Holds the cause value, the status fields and the non-maskable guard.
// It updates them only when a take strobe meets a valid request.
// Assumes gie_i is the status global-enable value the core holds now.
module irq_trap_csr #(
    parameter int unsigned XLEN = irq_entry_pkg::XLEN,
    parameter int unsigned IDW  = $clog2(XLEN)
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            take_i,
    input  logic            valid_i,
    input  logic [IDW-1:0]  id_i,
    input  logic            gie_i,
    input  logic            nmi_done_i,
    output logic [XLEN-1:0] cause_o,
    output logic            mie_o,
    output logic            mpie_o,
    output logic [1:0]      priv_o,
    output logic            nmi_busy_o
);
    localparam logic [IDW-1:0] NMI_ID = IDW'(XLEN - 1);

    logic entry;
    assign entry = take_i & valid_i;

    // Write cause and status fields on trap entry.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cause_o <= '0;
            mie_o   <= 1'b0;
            mpie_o  <= 1'b0;
            priv_o  <= irq_entry_pkg::PRIV_MACH;
        end else if (entry) begin
            cause_o <= {1'b1, {(XLEN-1-IDW){1'b0}}, id_i};
            mpie_o  <= gie_i;
            mie_o   <= 1'b0;
            priv_o  <= irq_entry_pkg::PRIV_MACH;
        end
    end

    // Arm the guard on a non-maskable entry and release it on handler done.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                     nmi_busy_o <= 1'b0;
        else if (entry && id_i == NMI_ID) nmi_busy_o <= 1'b1;
        else if (nmi_done_i)             nmi_busy_o <= 1'b0;
    end
endmodule

// File: rtl/irq_entry_unit.sv
// Top of the machine-mode interrupt entry unit: registers the request
// lines, selects the highest eligible request and computes cause and
// status on trap entry. The readable pending vector hides the top bit.
module irq_entry_unit #(
    parameter int unsigned XLEN     = irq_entry_pkg::XLEN,
    parameter int unsigned NUM_FAST = irq_entry_pkg::NUM_FAST,
    parameter int unsigned IDW      = $clog2(XLEN)
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                sw_req_i,
    input  logic                tmr_req_i,
    input  logic                ext_req_i,
    input  logic [NUM_FAST-1:0] fast_req_i,
    input  logic                nmi_req_i,
    input  logic [XLEN-2:0]     enable_i,
    input  logic                gie_i,
    input  logic                take_i,
    input  logic                nmi_done_i,
    output logic [XLEN-1:0]     pending_o,
    output logic                irq_valid_o,
    output logic [IDW-1:0]      irq_id_o,
    output logic [XLEN-1:0]     cause_o,
    output logic                stat_mie_o,
    output logic                stat_mpie_o,
    output logic [1:0]          stat_priv_o
);
    logic [XLEN-1:0] pend;
    logic            nmi_busy;

    irq_pend_reg #(.XLEN(XLEN), .NUM_FAST(NUM_FAST),
                   .FAST_BASE(irq_entry_pkg::FAST_BASE)) u_pend (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .sw_req_i   (sw_req_i),
        .tmr_req_i  (tmr_req_i),
        .ext_req_i  (ext_req_i),
        .fast_req_i (fast_req_i),
        .nmi_req_i  (nmi_req_i),
        .pend_o     (pend)
    );

    irq_select #(.XLEN(XLEN), .IDW(IDW)) u_sel (
        .pend_i      (pend),
        .enable_i    (enable_i),
        .gie_i       (gie_i),
        .nmi_block_i (nmi_busy),
        .valid_o     (irq_valid_o),
        .id_o        (irq_id_o)
    );

    irq_trap_csr #(.XLEN(XLEN), .IDW(IDW)) u_csr (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .take_i     (take_i),
        .valid_i    (irq_valid_o),
        .id_i       (irq_id_o),
        .gie_i      (gie_i),
        .nmi_done_i (nmi_done_i),
        .cause_o    (cause_o),
        .mie_o      (stat_mie_o),
        .mpie_o     (stat_mpie_o),
        .priv_o     (stat_priv_o),
        .nmi_busy_o (nmi_busy)
    );

    // The non-maskable source has no readable pending bit.
    assign pending_o = {1'b0, pend[XLEN-2:0]};
endmodule

// File: rtl/irq_entry_chk.sv
// Checker for the interrupt entry unit, watching only its ports.
// It keeps its own record of an open non-maskable trap.
module irq_entry_chk #(
    parameter int unsigned XLEN = irq_entry_pkg::XLEN,
    parameter int unsigned IDW  = $clog2(XLEN)
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic [XLEN-2:0] enable_i,
    input logic            gie_i,
    input logic            take_i,
    input logic            nmi_done_i,
    input logic [XLEN-1:0] pending_o,
    input logic            irq_valid_o,
    input logic [IDW-1:0]  irq_id_o,
    input logic [XLEN-1:0] cause_o,
    input logic            stat_mie_o,
    input logic            stat_mpie_o,
    input logic [1:0]      stat_priv_o
);
    localparam logic [IDW-1:0] NMI_ID = IDW'(XLEN - 1);

    logic nmi_open;

    // Track an open non-maskable trap from the port side.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                                        nmi_open <= 1'b0;
        else if (take_i && irq_valid_o && irq_id_o == NMI_ID) nmi_open <= 1'b1;
        else if (nmi_done_i)                                nmi_open <= 1'b0;
    end

    // R2
    pend_top_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pending_o[XLEN-1] == 1'b0);

    // R4
    mask_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_valid_o && irq_id_o != NMI_ID) |-> (gie_i && enable_i[irq_id_o] && pending_o[irq_id_o]));

    // R7
    cause_on_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (take_i && irq_valid_o) |=> (cause_o == {1'b1, {(XLEN-1-IDW){1'b0}}, $past(irq_id_o)}));

    // R8
    status_on_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (take_i && irq_valid_o) |=> (!stat_mie_o && stat_priv_o == 2'b11 && stat_mpie_o == $past(gie_i)));

    // R9
    idle_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (take_i && !irq_valid_o) |=> ($stable(cause_o) && $stable(stat_mpie_o) && $stable(stat_mie_o)));

    // R10
    nmi_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        nmi_open |-> !(irq_valid_o && irq_id_o == NMI_ID));

    // R11
    reset_state_chk: assert property (@(posedge clk_i)
        !rst_ni |=> (pending_o == '0 && cause_o == '0 && stat_priv_o == 2'b11 && !stat_mie_o && !stat_mpie_o));
endmodule

bind irq_entry_unit irq_entry_chk #(.XLEN(XLEN), .IDW(IDW)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enable_i    (enable_i),
    .gie_i       (gie_i),
    .take_i      (take_i),
    .nmi_done_i  (nmi_done_i),
    .pending_o   (pending_o),
    .irq_valid_o (irq_valid_o),
    .irq_id_o    (irq_id_o),
    .cause_o     (cause_o),
    .stat_mie_o  (stat_mie_o),
    .stat_mpie_o (stat_mpie_o),
    .stat_priv_o (stat_priv_o)
);

// File: tb/sim_irq_entry_unit.sv
module sim_irq_entry_unit;
    localparam int CLK_PERIOD = 10;
    localparam logic [30:0] EN_ALL = 31'h7FFF_FFFF;

    typedef struct packed {
        logic        sw;
        logic        tmr;
        logic        ext;
        logic [14:0] fast;
        logic        nmi;
        logic [30:0] en;
        logic        gie;
        logic        ev;
        logic [4:0]  eid;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 1'b0, 1'b0, 15'h0000, 1'b0, EN_ALL,        1'b1, 1'b1, 5'd3},
        '{1'b1, 1'b1, 1'b1, 15'h0000, 1'b0, EN_ALL,        1'b1, 1'b1, 5'd11},
        '{1'b1, 1'b1, 1'b1, 15'h0000, 1'b0, 31'h7FFF_F7FF, 1'b1, 1'b1, 5'd7},
        '{1'b0, 1'b0, 1'b1, 15'h0001, 1'b0, EN_ALL,        1'b1, 1'b1, 5'd16},
        '{1'b0, 1'b0, 1'b0, 15'h4008, 1'b0, EN_ALL,        1'b1, 1'b1, 5'd30},
        '{1'b0, 1'b0, 1'b0, 15'h7FFF, 1'b0, EN_ALL,        1'b0, 1'b0, 5'd0},
        '{1'b0, 1'b0, 1'b1, 15'h0000, 1'b1, 31'h0000_0000, 1'b0, 1'b1, 5'd31},
        '{1'b0, 1'b0, 1'b0, 15'h0000, 1'b0, EN_ALL,        1'b1, 1'b0, 5'd0},
        '{1'b0, 1'b1, 1'b0, 15'h0000, 1'b0, 31'h7FFF_FF7F, 1'b1, 1'b0, 5'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw = 1'b0, tmr = 1'b0, ext = 1'b0, nmi = 1'b0;
    logic [14:0] fast = '0;
    logic [30:0] en = '0;
    logic        gie = 1'b0, take = 1'b0, done = 1'b0;
    logic [31:0] pending, cause;
    logic        valid, mie, mpie;
    logic [4:0]  id;
    logic [1:0]  priv;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_entry_unit u0 (
        .clk_i(clk), .rst_ni(rst_n), .sw_req_i(sw), .tmr_req_i(tmr),
        .ext_req_i(ext), .fast_req_i(fast), .nmi_req_i(nmi), .enable_i(en),
        .gie_i(gie), .take_i(take), .nmi_done_i(done), .pending_o(pending),
        .irq_valid_o(valid), .irq_id_o(id), .cause_o(cause),
        .stat_mie_o(mie), .stat_mpie_o(mpie), .stat_priv_o(priv)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected readable pending vector from the packing rule (R1, R2).
    function automatic logic [31:0] pack_exp(input vec_t v);
        logic [31:0] p = '0;
        p[3] = v.sw; p[7] = v.tmr; p[11] = v.ext;
        for (int k = 0; k < 15; k++) p[16+k] = v.fast[k];
        return p;
    endfunction

    task automatic drive(input vec_t v);
        sw = v.sw; tmr = v.tmr; ext = v.ext; fast = v.fast;
        nmi = v.nmi; en = v.en; gie = v.gie;
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 pending", pending, 32'h0);
        chk("R11 cause", cause, 32'h0);
        chk("R11 priv", {30'h0, priv}, 32'h3);
        chk("R11 mie/mpie", {30'h0, mie, mpie}, 32'h0);
        rst_n = 1'b1;

        // Table walk: R1 R2 R3 R4 R5 R6
        for (int i = 0; i < NV; i++) begin
            drive(TBL[i]);
            @(negedge clk);
            chk($sformatf("R1/R2 pending row %0d", i), pending, pack_exp(TBL[i]));
            chk($sformatf("R3-R6 valid row %0d", i), {31'h0, valid}, {31'h0, TBL[i].ev});
            chk($sformatf("R3 id row %0d", i), {27'h0, id}, {27'h0, TBL[i].eid});
        end

        // R12 line drop clears pending one edge later
        drive('0);
        en = EN_ALL; gie = 1'b1; tmr = 1'b1;
        @(negedge clk);
        chk("R12 held", pending, 32'h0000_0080);
        tmr = 1'b0;
        @(negedge clk);
        chk("R12 dropped", pending, 32'h0);

        // R7 R8: take coincides with a higher line being registered
        ext = 1'b1;
        @(negedge clk);
        take = 1'b1; fast[5] = 1'b1;
        @(negedge clk);
        take = 1'b0;
        chk("R7 cause keeps strobe-cycle id", cause, 32'h8000_000B);
        chk("R3 new id after edge", {27'h0, id}, 32'd21);
        chk("R8 status", {29'h0, mie, mpie, priv}, {29'h0, 1'b0, 1'b1, 2'b11});

        // R9 take with nothing valid
        ext = 1'b0; fast = '0;
        @(negedge clk);
        gie = 1'b0; take = 1'b1;
        @(negedge clk);
        take = 1'b0;
        chk("R9 cause unchanged", cause, 32'h8000_000B);
        chk("R9 mpie unchanged", {31'h0, mpie}, 32'h1);

        // R6 R8: NMI with global enable low gives mpie 0
        nmi = 1'b1; ext = 1'b1;
        @(negedge clk);
        chk("R6 nmi valid", {26'h0, valid, id}, {26'h0, 1'b1, 5'd31});
        take = 1'b1;
        @(negedge clk);
        take = 1'b0;
        chk("R7 nmi cause", cause, 32'h8000_001F);
        chk("R8 mpie from gie", {31'h0, mpie}, 32'h0);

        // R10 guard: held NMI blocked, ext still selectable
        chk("R10 blocked no other", {31'h0, valid}, 32'h0);
        gie = 1'b1;
        @(negedge clk);
        chk("R10 ext during guard", {27'h0, id}, 32'd11);
        @(negedge clk);
        chk("R10 still blocked", {27'h0, id}, 32'd11);
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        chk("R10 released", {26'h0, valid, id}, {26'h0, 1'b1, 5'd31});

        // R11 mid-run reset
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11 rerun cause", cause, 32'h0);
        chk("R11 rerun pending", pending, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 guard cleared", {26'h0, valid, id}, {26'h0, 1'b1, 5'd31});

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule